// File: doc/BRIEF.md
# HDLC Bit-Serial Frame Transmitter

This block turns a queue of tagged bytes into a bit-serial HDLC line signal. It reads a byte FIFO through a show-ahead interface. Each entry carries two tags besides its byte: a last-byte tag, which closes the packet, and an abort tag, which kills it. The tags let several packets sit in the queue back to back. Framing covers the opening and closing flags, zero insertion over the data and the check sequence, and a 16-bit frame check sequence after every last-tagged byte. The block moves one line bit per strobe on `bit_tick`, so an external line interface sets the bit rate.

With the queue empty, the line carries either continuous ones or back-to-back flags, chosen by `idle_flags`. When `tx_enable` drops, the packet in flight runs to its end before the line goes quiet. A raw mode bypasses all framing and only serialises bytes. That mode is entered on a falling edge of `tx_enable` while `transparent` is high, and the same edge resets the byte alignment. If the queue runs dry inside a packet, the block aborts that packet and raises a flag.

Top module: `hdlc_tx`

## Requirements
- R1: Following reset, `tx_bit` is 1, `underrun` is 0 and `fifo_pop` is 0. While the transmitter is disabled and no packet is in flight, the line stays at 1.
- R2: When enabled with an empty FIFO and `idle_flags`=0, every bit sent is a 1.
- R3: When enabled with an empty FIFO and `idle_flags`=1, the line repeats the flag 0x7E, sent as the bits 0,1,1,1,1,1,1,0.
- R4: Every byte goes out least significant bit first. A frame is an opening flag 0x7E, then the data bytes, then the check sequence, then a closing flag 0x7E.
- R5: The check sequence is a reflected CRC-16 (polynomial 0x8408, preset 0xFFFF), complemented and sent low byte first. For the data "123456789" (0x31..0x39), the line carries 0x6E and then 0x90.
- R6: After any five consecutive ones inside the data or check-sequence fields, a 0 is inserted. Flags, idle patterns and aborts carry no inserted zeros.
- R7: A byte with `fifo_last`=1 ends its packet. Packets queued back to back each leave as a separate frame, in FIFO order.
- R8: Popping a byte with `fifo_abort`=1 sends at least seven consecutive ones. If that byte is not last-tagged, the following entries up to and including the next last-tagged byte are popped and never sent. The next packet then goes out normally.
- R9: If the FIFO is empty when a packet needs its next data byte, the packet is aborted with ones and `underrun` goes to 1. `underrun` stays at 1 until the next opening flag begins.
- R10: Once `tx_enable` is deasserted, the packet in flight is sent complete. After it, the line is held at 1 and no more entries are popped.
- R11: When `tx_enable` is asserted from the stopped state, the first bit of an opening flag or idle pattern goes out on the first strobe.
- R12: Raw mode is entered on a falling edge of `tx_enable` while `transparent`=1, and it realigns the byte boundary. In raw mode, bytes are sent exactly as stored, least significant bit first, with no flags, check sequence or inserted zeros, and with ones while the FIFO is empty.
- R13: `fifo_pop` is never asserted while `fifo_empty` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bit_tick | input | 1 | Strobe: one line bit per cycle in which it is high |
| tx_enable | input | 1 | Transmit enable |
| idle_flags | input | 1 | Idle fill select: 0 ones, 1 flags |
| transparent | input | 1 | Raw serialisation mode select |
| fifo_empty | input | 1 | FIFO holds no entry |
| fifo_byte | input | 8 | Head entry data byte |
| fifo_last | input | 1 | Head entry closes its packet |
| fifo_abort | input | 1 | Head entry aborts its packet |
| fifo_pop | output | 1 | Consume the head entry |
| tx_bit | output | 1 | Serial line output |
| underrun | output | 1 | Packet aborted because the FIFO ran dry |

## Verification
The bench uses the default parameters: a stuffing run of five, preset 0xFFFF and polynomial 0x8408. With these, the known "123456789" check value can be compared directly, and payloads of 0xFF and 0x7E bytes exercise zero insertion next to flag-like patterns. A strobe every second clock leaves idle cycles between bits, so FIFO draining during an abort runs between line bits. The same spacing checks that the line holds steady between strobes.

// File: rtl/hdlc_tx_pkg.sv
package hdlc_tx_pkg;

    localparam int BYTE_W = 8;
    localparam int CNT_W  = $clog2(BYTE_W);
    localparam logic [BYTE_W-1:0] FLAG_PAT = 8'h7E;
    localparam logic [BYTE_W-1:0] ONES_PAT = 8'hFF;

    typedef enum logic [3:0] {
        PH_OFF, PH_IDLE, PH_OPEN, PH_DATA, PH_FCS_LO,
        PH_FCS_HI, PH_CLOSE, PH_ABORT, PH_RAW
    } phase_e;

    typedef struct packed {
        phase_e            ph;
        logic [BYTE_W-1:0] pat;
    } unit_t;

    function automatic logic is_stuffed(input phase_e ph);
        return ph inside {PH_DATA, PH_FCS_LO, PH_FCS_HI};
    endfunction

    function automatic logic [15:0] crc_step(input logic [15:0] c,
                                             input logic [BYTE_W-1:0] d,
                                             input logic [15:0] poly);
        logic [15:0] r;
        r = c;
        for (int i = 0; i < BYTE_W; i++) begin
            if (r[0] ^ d[i]) r = (r >> 1) ^ poly;
            else             r = r >> 1;
        end
        return r;
    endfunction

endpackage

// File: rtl/hdlc_tx_crc.sv
module hdlc_tx_crc
    import hdlc_tx_pkg::*;
#(
    parameter logic [15:0] PRESET = 16'hFFFF,
    parameter logic [15:0] POLY   = 16'h8408
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              init,
    input  logic              feed,
    input  logic [BYTE_W-1:0] data_in,
    output logic [15:0]       crc
);

    always_ff @(posedge clk) begin
        if (rst || init) crc <= PRESET;
        else if (feed)   crc <= crc_step(crc, data_in, POLY);
    end

endmodule

// File: rtl/hdlc_tx_select.sv
module hdlc_tx_select
    import hdlc_tx_pkg::*;
(
    input  phase_e            ph,
    input  logic              trans_mode,
    input  logic              discard,
    input  logic              tx_enable,
    input  logic              idle_flags,
    input  logic              fifo_empty,
    input  logic [BYTE_W-1:0] fifo_byte,
    input  logic              fifo_last,
    input  logic              fifo_abort,
    input  logic              eop_pend,
    input  logic [15:0]       crc,
    output unit_t             nxt,
    output logic              take,
    output logic              start_discard,
    output logic              set_underrun,
    output logic              crc_init,
    output logic              crc_feed
);

    logic have_byte;
    assign have_byte = !fifo_empty && !discard;

    always_comb begin
        nxt           = '{ph: PH_IDLE, pat: ONES_PAT};
        take          = 1'b0;
        start_discard = 1'b0;
        set_underrun  = 1'b0;
        crc_init      = 1'b0;
        crc_feed      = 1'b0;
        if (trans_mode) begin
            if (have_byte) begin
                nxt  = '{ph: PH_RAW, pat: fifo_byte};
                take = 1'b1;
            end else begin
                nxt = '{ph: PH_RAW, pat: ONES_PAT};
            end
        end else begin
            case (ph)
                PH_OPEN, PH_DATA: begin
                    if (ph == PH_DATA && eop_pend) begin
                        nxt = '{ph: PH_FCS_LO, pat: ~crc[7:0]};
                    end else if (fifo_empty) begin
                        nxt          = '{ph: PH_ABORT, pat: ONES_PAT};
                        set_underrun = 1'b1;
                    end else if (fifo_abort) begin
                        nxt           = '{ph: PH_ABORT, pat: ONES_PAT};
                        take          = 1'b1;
                        start_discard = !fifo_last;
                    end else begin
                        nxt      = '{ph: PH_DATA, pat: fifo_byte};
                        take     = 1'b1;
                        crc_feed = 1'b1;
                    end
                end
                PH_FCS_LO: nxt = '{ph: PH_FCS_HI, pat: ~crc[15:8]};
                PH_FCS_HI: nxt = '{ph: PH_CLOSE, pat: FLAG_PAT};
                default: begin
                    if (!tx_enable) begin
                        nxt = '{ph: PH_OFF, pat: ONES_PAT};
                    end else if (have_byte) begin
                        nxt      = '{ph: PH_OPEN, pat: FLAG_PAT};
                        crc_init = 1'b1;
                    end else begin
                        nxt = '{ph: PH_IDLE, pat: idle_flags ? FLAG_PAT : ONES_PAT};
                    end
                end
            endcase
        end
    end

endmodule

// File: rtl/hdlc_tx.sv
module hdlc_tx
    import hdlc_tx_pkg::*;
#(
    parameter int          STUFF_RUN  = 5,
    parameter logic [15:0] CRC_PRESET = 16'hFFFF,
    parameter logic [15:0] CRC_POLY   = 16'h8408
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              bit_tick,
    input  logic              tx_enable,
    input  logic              idle_flags,
    input  logic              transparent,
    input  logic              fifo_empty,
    input  logic [BYTE_W-1:0] fifo_byte,
    input  logic              fifo_last,
    input  logic              fifo_abort,
    output logic              fifo_pop,
    output logic              tx_bit,
    output logic              underrun
);

    localparam int OW = $clog2(STUFF_RUN + 1);

    phase_e            ph;
    logic [BYTE_W-1:0] sh;
    logic [CNT_W-1:0]  cnt;
    logic [OW-1:0]     ones;
    logic              trans_mode, en_q, discard, eop_pend;
    logic [15:0]       crc;

    unit_t nxt, cur;
    logic  take, start_discard, set_underrun, crc_init, crc_feed;
    logic  fall, force_align, stuff_now, boundary, load;

    assign fall        = en_q && !tx_enable;
    assign force_align = (fall && transparent) || (trans_mode && !transparent);
    assign stuff_now   = (ones == OW'(STUFF_RUN));
    assign boundary    = (cnt == '0) || (ph == PH_OFF);
    assign load        = bit_tick && !stuff_now && boundary && !force_align;
    assign fifo_pop    = (load && take) || (discard && !fifo_empty);

    always_comb begin
        if (load) cur = nxt;
        else      cur = '{ph: ph, pat: sh};
    end

    hdlc_tx_select u_select (
        .ph(ph), .trans_mode(trans_mode), .discard(discard),
        .tx_enable(tx_enable), .idle_flags(idle_flags),
        .fifo_empty(fifo_empty), .fifo_byte(fifo_byte),
        .fifo_last(fifo_last), .fifo_abort(fifo_abort),
        .eop_pend(eop_pend), .crc(crc), .nxt(nxt), .take(take),
        .start_discard(start_discard), .set_underrun(set_underrun),
        .crc_init(crc_init), .crc_feed(crc_feed)
    );

    hdlc_tx_crc #(.PRESET(CRC_PRESET), .POLY(CRC_POLY)) u_crc (
        .clk(clk), .rst(rst), .init(load && crc_init),
        .feed(load && crc_feed), .data_in(fifo_byte), .crc(crc)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            ph         <= PH_OFF;
            sh         <= ONES_PAT;
            cnt        <= '0;
            ones       <= '0;
            tx_bit     <= 1'b1;
            trans_mode <= 1'b0;
            en_q       <= 1'b0;
            discard    <= 1'b0;
            eop_pend   <= 1'b0;
            underrun   <= 1'b0;
        end else begin
            en_q       <= tx_enable;
            trans_mode <= transparent && (trans_mode || fall);
            if (force_align) begin
                ph   <= PH_OFF;
                cnt  <= '0;
                ones <= '0;
            end else if (bit_tick) begin
                if (stuff_now) begin
                    tx_bit <= 1'b0;
                    ones   <= '0;
                end else begin
                    tx_bit <= cur.pat[0];
                    sh     <= {1'b1, cur.pat[BYTE_W-1:1]};
                    ph     <= cur.ph;
                    cnt    <= load ? CNT_W'(1) : cnt + 1'b1;
                    if (is_stuffed(cur.ph) && cur.pat[0]) ones <= ones + 1'b1;
                    else                                  ones <= '0;
                end
            end
            if (load && start_discard)                     discard <= 1'b1;
            else if (discard && !fifo_empty && fifo_last)  discard <= 1'b0;
            if (load && crc_feed)     eop_pend <= fifo_last;
            if (load && set_underrun) underrun <= 1'b1;
            else if (load && crc_init) underrun <= 1'b0;
        end
    end

endmodule

// File: rtl/hdlc_tx_checker.sv
module hdlc_tx_checker (
    input logic clk,
    input logic rst,
    input logic bit_tick,
    input logic tx_bit,
    input logic fifo_pop,
    input logic fifo_empty,
    input logic underrun
);

    assert_reset_state_R1: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> (tx_bit && !underrun && !fifo_pop));

    assert_line_holds_R4: assert property (@(posedge clk) disable iff (rst)
        !$past(bit_tick) |-> $stable(tx_bit));

    assert_underrun_cause_R9: assert property (@(posedge clk) disable iff (rst)
        $rose(underrun) |-> $past(fifo_empty));

    assert_pop_nonempty_R13: assert property (@(posedge clk) disable iff (rst)
        fifo_pop |-> !fifo_empty);

endmodule

bind hdlc_tx hdlc_tx_checker u_chk (.*);

// File: tb/hdlc_tx_bench.sv
module hdlc_tx_bench;

    logic clk = 0, rst = 1, bit_tick = 0, tx_enable = 0, idle_flags = 0, transparent = 0;
    logic fifo_empty, fifo_last, fifo_abort, fifo_pop, tx_bit, underrun;
    logic [7:0] fifo_byte;

    always #10 clk = ~clk;

    logic [9:0] mem [0:1023];
    int rd, wr;
    assign fifo_empty = (rd == wr);
    assign {fifo_abort, fifo_last, fifo_byte} = mem[rd[9:0]];

    always @(posedge clk) begin
        if (rst) rd <= 0;
        else if (fifo_pop) rd <= rd + 1;
    end

    hdlc_tx u_hdlc_tx (.*);

    int tests = 0, fails = 0, cyc = 0, pop_err = 0;
    logic cap_on = 0, tick_seen = 0;
    logic cap[$];
    logic [7:0] exp_q[$];
    logic [7:0] dec_bytes[$];
    int dec_start[$], dec_len[$];
    int n_abort, n_bad;

    always @(negedge clk) bit_tick <= ~bit_tick;
    always @(posedge clk) tick_seen <= bit_tick;
    always @(negedge clk) if (cap_on && tick_seen) cap.push_back(tx_bit);
    always @(posedge clk) if (!rst && fifo_pop && fifo_empty) pop_err++;

    always @(posedge clk) begin
        cyc++;
        if (cyc > 150000) begin
            fails++;
            $display("FAIL watchdog: actual %0d cycles, expected fewer", cyc);
            $display("[TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end

    task automatic check(input string req, input int act, input int exp);
        tests++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s: actual %0d (0x%0h) expected %0d (0x%0h)", req, act, act, exp, exp);
        end
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst = 1; tx_enable = 0; idle_flags = 0; transparent = 0;
        wr = 0; cap_on = 0; cap.delete();
        repeat (3) @(negedge clk);
        rst = 0;
        @(negedge clk);
    endtask

    task automatic push(input logic [7:0] b, input logic last, input logic abrt);
        mem[wr[9:0]] = {abrt, last, b};
        wr++;
    endtask

    task automatic push_exp();
        foreach (exp_q[i]) push(exp_q[i], i == exp_q.size() - 1, 1'b0);
    endtask

    task automatic start(input logic flags);
        idle_flags = flags; tx_enable = 1;
        @(posedge clk);
        cap_on = 1;
    endtask

    task automatic wait_bits(input int n);
        int target;
        target = cap.size() + n;
        while (cap.size() < target) @(negedge clk);
    endtask

    function automatic logic [15:0] ref_fcs();
        logic [15:0] c;
        c = 16'hFFFF;
        foreach (exp_q[i]) begin
            for (int k = 0; k < 8; k++) begin
                logic fb;
                fb = c[0] ^ exp_q[i][k];
                c = c >> 1;
                if (fb) c = c ^ 16'h8408;
            end
        end
        return ~c;
    endfunction

    task automatic decode();
        int ones;
        logic in_fr;
        logic bits[$];
        ones = 0; in_fr = 0; n_abort = 0; n_bad = 0;
        dec_bytes.delete(); dec_start.delete(); dec_len.delete();
        foreach (cap[i]) begin
            if (cap[i]) begin
                ones++;
                bits.push_back(1'b1);
                if (ones == 7 && in_fr) begin n_abort++; in_fr = 0; end
            end else begin
                if (ones == 5) begin
                end else if (ones == 6) begin
                    repeat (7) if (bits.size() > 0) void'(bits.pop_back());
                    if (in_fr && bits.size() > 0) begin
                        if (bits.size() % 8 == 0 && bits.size() >= 24) begin
                            dec_start.push_back(dec_bytes.size());
                            dec_len.push_back(bits.size() / 8);
                            for (int j = 0; j < bits.size() / 8; j++) begin
                                logic [7:0] b;
                                for (int k = 0; k < 8; k++) b[k] = bits[j*8+k];
                                dec_bytes.push_back(b);
                            end
                        end else n_bad++;
                    end
                    bits.delete();
                    in_fr = 1;
                end else bits.push_back(1'b0);
                ones = 0;
            end
        end
    endtask

    task automatic check_frame(input int idx, input string req);
        int s, n, errs;
        logic [15:0] f;
        if (idx >= dec_len.size()) begin
            check(req, -1, idx);
            return;
        end
        s = dec_start[idx]; n = exp_q.size(); errs = 0;
        check(req, dec_len[idx], n + 2);
        if (dec_len[idx] == n + 2) begin
            foreach (exp_q[i]) if (dec_bytes[s+i] != exp_q[i]) errs++;
            f = ref_fcs();
            if (dec_bytes[s+n] != f[7:0] || dec_bytes[s+n+1] != f[15:8]) errs++;
        end
        check(req, errs, 0);
    endtask

    task automatic t_reset();
        do_reset();
        check("R1 line after reset", tx_bit, 1);
        check("R1 underrun after reset", underrun, 0);
        check("R1 pop after reset", fifo_pop, 0);
        push(8'h55, 1'b1, 1'b0);
        cap_on = 1;
        wait_bits(30);
        check("R1 disabled line ones", cap.sum() with (int'(item)), 30);
        check("R1 disabled keeps fifo", wr - rd, 1);
    endtask

    task automatic t_mark_idle();
        do_reset();
        start(1'b0);
        wait_bits(40);
        check("R2 mark idle ones", cap.sum() with (int'(item)), 40);
    endtask

    task automatic t_flag_fill();
        int errs;
        logic [7:0] fl;
        do_reset();
        start(1'b1);
        wait_bits(48);
        errs = 0; fl = 8'h7E;
        for (int i = 0; i < 48; i++) if (cap[i] != fl[i % 8]) errs++;
        check("R3 R11 flag fill from first strobe", errs, 0);
    endtask

    task automatic t_known_fcs();
        do_reset();
        exp_q = '{8'h31, 8'h32, 8'h33, 8'h34, 8'h35, 8'h36, 8'h37, 8'h38, 8'h39};
        push_exp();
        start(1'b1);
        wait_bits(200);
        decode();
        check("R4 frame count", dec_len.size(), 1);
        check_frame(0, "R4 R5 frame content");
        if (dec_len.size() > 0 && dec_len[0] == 11) begin
            check("R5 fcs low byte", dec_bytes[9], 8'h6E);
            check("R5 fcs high byte", dec_bytes[10], 8'h90);
        end
        check("R4 no malformed frames", n_bad, 0);
    endtask

    task automatic t_stuffing();
        do_reset();
        exp_q = '{8'hFF, 8'hFF, 8'h7E, 8'h3E, 8'hF8};
        push_exp();
        start(1'b0);
        wait_bits(160);
        decode();
        check("R6 stuffed frame count", dec_len.size(), 1);
        check_frame(0, "R6 stuffed frame content");
    endtask

    task automatic t_back_to_back();
        do_reset();
        exp_q = '{8'hA1, 8'hB2, 8'hC3}; push_exp();
        exp_q = '{8'h0F, 8'hF0};       push_exp();
        start(1'b1);
        wait_bits(240);
        decode();
        check("R7 two frames", dec_len.size(), 2);
        exp_q = '{8'hA1, 8'hB2, 8'hC3}; check_frame(0, "R7 first frame");
        exp_q = '{8'h0F, 8'hF0};       check_frame(1, "R7 second frame");
    endtask

    task automatic t_abort();
        do_reset();
        push(8'h11, 1'b0, 1'b0);
        push(8'h22, 1'b0, 1'b1);
        push(8'h33, 1'b0, 1'b0);
        push(8'h44, 1'b1, 1'b0);
        exp_q = '{8'h55, 8'h66}; push_exp();
        start(1'b1);
        wait_bits(240);
        decode();
        check("R8 abort seen", n_abort, 1);
        check("R8 only next packet framed", dec_len.size(), 1);
        check_frame(0, "R8 packet after abort");
        check("R8 fifo drained", wr - rd, 0);
    endtask

    task automatic t_underrun();
        do_reset();
        push(8'h12, 1'b0, 1'b0);
        push(8'h34, 1'b0, 1'b0);
        start(1'b1);
        wait_bits(120);
        check("R9 underrun raised", underrun, 1);
        decode();
        check("R9 abort on underrun", n_abort, 1);
        check("R9 no frame on underrun", dec_len.size(), 0);
        exp_q = '{8'hAB, 8'hCD}; push_exp();
        wait_bits(120);
        check("R9 underrun cleared by next frame", underrun, 0);
        decode();
        check_frame(0, "R9 frame after underrun");
    endtask

    task automatic t_release();
        int tail;
        do_reset();
        exp_q = '{8'h01, 8'h02, 8'h03, 8'h04, 8'h05}; push_exp();
        push(8'h77, 1'b0, 1'b0);
        push(8'h88, 1'b1, 1'b0);
        start(1'b0);
        wait_bits(20);
        @(negedge clk);
        tx_enable = 0;
        wait_bits(200);
        decode();
        check("R10 in-flight frame completed", dec_len.size(), 1);
        check_frame(0, "R10 completed frame content");
        check("R10 later packet kept", wr - rd, 2);
        tail = 0;
        for (int i = cap.size() - 30; i < cap.size(); i++) tail += int'(cap[i]);
        check("R10 line ones after stop", tail, 30);
    endtask

    task automatic t_transparent();
        logic [23:0] pat;
        int found;
        do_reset();
        transparent = 1;
        start(1'b0);
        wait_bits(10);
        @(negedge clk);
        tx_enable = 0;
        cap.delete();
        repeat (4) @(negedge clk);
        push(8'hA5, 1'b0, 1'b0);
        push(8'hFF, 1'b1, 1'b0);
        push(8'h00, 1'b0, 1'b0);
        wait_bits(80);
        pat = {8'h00, 8'hFF, 8'hA5};
        found = -1;
        for (int k = 0; k + 24 <= cap.size() && found < 0; k++) begin
            if (cap[k] == 1'b0 || k + 24 == cap.size()) begin
                int ok;
                ok = 1;
                for (int j = 0; j < 24; j++) if (k + j >= 1 && cap[k-1+j] != pat[j]) ok = 0;
                if (k >= 1 && ok == 1) found = k - 1;
                if (found < 0) break;
            end
        end
        check("R12 raw bytes sent unstuffed", found >= 0, 1);
        if (found >= 0) begin
            int lead, trail;
            lead = 0; trail = 0;
            for (int i = 0; i < found; i++) lead += int'(cap[i]);
            for (int i = found + 24; i < cap.size(); i++) trail += int'(cap[i]);
            check("R12 ones before raw bytes", lead, found);
            check("R12 ones after raw bytes", trail, cap.size() - found - 24);
        end
        check("R12 raw bytes consumed", wr - rd, 0);
    endtask

    initial begin
        t_reset();
        t_mark_idle();
        t_flag_fill();
        t_known_fcs();
        t_stuffing();
        t_back_to_back();
        t_abort();
        t_underrun();
        t_release();
        t_transparent();
        check("R13 no pop while empty", pop_err, 0);
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

endmodule